// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer between two unrelated clock domains. One side writes 18-bit words on its own clock and the other side reads them on its own clock. The default storage is 1024 words. Both strobes are active low. The writer sees a room indicator, an almost-full flag and a more-than-half flag. The reader sees a data-available indicator and an almost-empty flag. The full, empty and two threshold flags all read low when their condition holds.

The almost-empty and almost-full thresholds are held in two 12-bit offset registers. Software loads and reads them through the normal data ports while the load strobe is held low. Successive load accesses alternate between the empty offset and the full offset. A static mode pin selects the read behaviour:

- **Standard mode:** a word reaches the output register only when a read is requested.
- **Fall-through mode:** the head word is presented on its own, and the data-available output means "a valid word is on the bus now".

The output bus goes to high impedance while the output enable is high. Pointers cross between the domains as Gray code through two-flop synchronisers.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high on the clock edges of both domains, both pointers return to location zero, both offsets return to 127, and both load sequences return to the empty offset. After reset, `data_ok`=0, `almost_empty_n`=0, `space_ok`=1, `almost_full_n`=1 and `over_half_n`=1.
- R2: A word is stored on a rising `wclk` edge only when `wen_n`=0, `ld_n`=1 and `space_ok`=1. A write attempted while full is dropped and never appears at the output.
- R3: In standard mode, a word is removed on a rising `rclk` edge only when `ren_n`=0, `ld_n`=1 and `data_ok`=1, and that word is on `q` after the same edge. With `ren_n`=1, or when empty, `q` keeps its value.
- R4: Words leave in exactly the order they were written.
- R5: `space_ok` is low when 1024 words are held. It falls on the write edge that stores the last free location, with no synchroniser delay.
- R6: In standard mode, `data_ok` is low when no word is held. It falls on the read edge that removes the last word, with no synchroniser delay.
- R7: `almost_empty_n` is low exactly when the held count is at or below the empty offset.
- R8: `almost_full_n` is low exactly when the free space (1024 minus the held count) is at or below the full offset.
- R9: `over_half_n` is low exactly when more than 512 words are held.
- R10: A rising `wclk` edge with `ld_n`=0 and `wen_n`=0 stores `d[11:0]` into an offset register instead of the memory. The first such access after reset sets the empty offset, the second sets the full offset, and the third wraps back to the empty offset.
- R11: A rising `rclk` edge with `ld_n`=0 and `ren_n`=0 places an offset on `q[11:0]` with `q[17:12]`=0, following the same empty-then-full alternation, and removes no word.
- R12: With `fwft`=1, the head word appears on `q` and `data_ok` goes high without any read request. `ren_n`=0 consumes it, and the next word, if present, replaces it. `data_ok` stays high until the word is consumed.
- R13: While `oe_n`=1, every bit of `q` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held for several edges of both clocks |
| fwft | input | 1 | Static read mode: 0 standard, 1 fall-through |
| wen_n | input | 1 | Active-low write strobe |
| ren_n | input | 1 | Active-low read strobe |
| ld_n | input | 1 | Active-low load strobe for offset access |
| oe_n | input | 1 | Active-low output enable |
| d | input | 18 | Write data; bits 11:0 carry an offset during a load |
| q | output | 18 | Read data or offset read-back, tri-stated by `oe_n` |
| space_ok | output | 1 | High when a location is free; low means full |
| data_ok | output | 1 | High when data is held (standard) or valid on `q` (fall-through) |
| almost_full_n | output | 1 | Low when free space is at or below the full offset |
| almost_empty_n | output | 1 | Low when the held count is at or below the empty offset |
| over_half_n | output | 1 | Low when more than half the depth is held |

## Verification
The bench targets several boundaries, each chosen because a specific error would show up there:

- **Threshold and half-full edges.** The bench fills to counts 20/21, 512/513 and 993/994 with offsets of 20 and 30. An off-by-one comparison (`<` instead of `<=`, or `>=` instead of `>`) moves a flag one word early or late.
- **Flag lag at full and empty.** The last write into a full buffer and the last read from it are checked on the very next clock phase. A flag taken from the synchronised copy would assert two clocks late and let the overflow or underflow through.
- **Dropped writes.** A write attempted while full must not appear in the drained sequence.
- **Load alternation.** A load sequence that skips the wrap would leave the wrong offset in place.
- **Load read-back.** A read-back that also advanced the pointer would lose a word.
- **Fall-through presentation.** In fall-through mode, a missed automatic fetch shows up as a stale head word or as `data_ok` staying low.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;

    // Static read behaviour selected by the mode pin
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    // Which offset register the next load access touches
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    // Write-domain flag bundle
    typedef struct packed {
        logic room;      // high while a location is free
        logic afull_n;   // low when free space <= full offset
        logic half_n;    // low when more than half is held
    } wr_flags_t;

    // Read-domain flag bundle
    typedef struct packed {
        logic avail;     // data present / valid on the bus
        logic aempty_n;  // low when held count <= empty offset
    } rd_flags_t;

    localparam int DEF_DATA_W  = 18;
    localparam int DEF_ADDR_W  = 10;
    localparam int DEF_OFS_W   = 12;
    localparam int DEF_OFS_RST = 127;

    function automatic ofs_sel_e next_sel(input ofs_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

endpackage

// File: rtl/dcfifo_g2b.sv
`timescale 1ns/1ps
module dcfifo_g2b #(
    parameter int W = 11
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // Each binary bit is the parity of the Gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            dout   <= '0;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_mem.sv
`timescale 1ns/1ps
module dcfifo_mem #(
    parameter int DW = 18,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int DW      = 18,
    parameter int AW      = 10,
    parameter int OW      = 12,
    parameter int OFS_RST = 127
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wen_n,
    input  logic          ld_n,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [OW-1:0] ofs_ae,
    output logic [OW-1:0] ofs_af,
    output wr_flags_t     flags
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;
    localparam logic [PW-1:0] HALF_P  = DEPTH_P >> 1;

    logic [PW-1:0] wbin, wbin_nxt, rbin_s, level, free;
    logic          is_full, ld_wr;
    ofs_sel_e      sel;

    dcfifo_g2b #(.W(PW)) u_rconv (.gray(rgray_s), .bin(rbin_s));

    // Occupancy seen from the write side: never under-reports
    assign level    = wbin - rbin_s;
    assign free     = DEPTH_P - level;
    assign is_full  = (level == DEPTH_P);
    assign we       = !wen_n && ld_n && !is_full;
    assign ld_wr    = !wen_n && !ld_n;
    assign waddr    = wbin[AW-1:0];
    assign wbin_nxt = wbin + PW'(1);

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            ofs_ae <= OW'(OFS_RST);
            ofs_af <= OW'(OFS_RST);
            sel    <= SEL_AE;
        end else begin
            if (we) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
            end
            if (ld_wr) begin
                if (sel == SEL_AE) ofs_ae <= din[OW-1:0];
                else               ofs_af <= din[OW-1:0];
                sel <= next_sel(sel);
            end
        end
    end

    always_comb begin
        flags.room    = !is_full;
        flags.afull_n = !(32'(free) <= 32'(ofs_af));
        flags.half_n  = !(level > HALF_P);
    end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 10,
    parameter int OW = 12
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          ren_n,
    input  logic          ld_n,
    input  rd_mode_e      mode,
    input  logic [AW:0]   wgray_s,
    input  logic [OW-1:0] ofs_ae,
    input  logic [OW-1:0] ofs_af,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output rd_flags_t     flags,
    output logic [DW-1:0] dout
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rbin, rbin_nxt, wbin_s, mem_lvl, eff_lvl;
    logic          mem_empty, std_pop, take, fetch, adv, ld_rd, plain_rd;
    logic          out_vld, show_ofs;
    logic [DW-1:0] out_reg;
    logic [OW-1:0] shadow;
    ofs_sel_e      rsel;

    dcfifo_g2b #(.W(PW)) u_wconv (.gray(wgray_s), .bin(wbin_s));

    // Occupancy seen from the read side: never over-reports
    assign mem_lvl   = wbin_s - rbin;
    assign mem_empty = (mem_lvl == '0);
    assign plain_rd  = !ren_n && ld_n;
    assign ld_rd     = !ren_n && !ld_n;
    assign std_pop   = (mode == MODE_STD) && plain_rd && !mem_empty;
    assign take      = (mode == MODE_FWFT) && plain_rd && out_vld;
    assign fetch     = (mode == MODE_FWFT) && !mem_empty && (!out_vld || take);
    assign adv       = std_pop || fetch;
    assign rbin_nxt  = rbin + PW'(1);
    assign raddr     = rbin[AW-1:0];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin     <= '0;
            rgray    <= '0;
            out_reg  <= '0;
            out_vld  <= 1'b0;
            show_ofs <= 1'b0;
            shadow   <= '0;
            rsel     <= SEL_AE;
        end else begin
            if (adv) begin
                rbin    <= rbin_nxt;
                rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
                out_reg <= mem_q;
            end
            if (fetch)     out_vld <= 1'b1;
            else if (take) out_vld <= 1'b0;
            if (ld_rd) begin
                show_ofs <= 1'b1;
                shadow   <= (rsel == SEL_AE) ? ofs_ae : ofs_af;
                rsel     <= next_sel(rsel);
            end else if (plain_rd) begin
                show_ofs <= 1'b0;
            end
        end
    end

    // In fall-through mode the presented word still counts as held
    assign eff_lvl = mem_lvl + ((mode == MODE_FWFT) ? PW'(out_vld) : '0);

    always_comb begin
        flags.avail    = (mode == MODE_FWFT) ? out_vld : !mem_empty;
        flags.aempty_n = !(32'(eff_lvl) <= 32'(ofs_ae));
    end

    assign dout = show_ofs ? DW'(shadow) : out_reg;
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag
    import dcfifo_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int OFS_W   = DEF_OFS_W,
    parameter int OFS_RST = DEF_OFS_RST
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              fwft,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic              ld_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              space_ok,
    output logic              data_ok,
    output logic              almost_full_n,
    output logic              almost_empty_n,
    output logic              over_half_n
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [OFS_W-1:0]  ofs_ae, ofs_af;
    logic [DATA_W-1:0] mem_q, q_int;
    logic              we;
    wr_flags_t         wf;
    rd_flags_t         rf;

    dcfifo_wr_ctl #(.DW(DATA_W), .AW(ADDR_W), .OW(OFS_W), .OFS_RST(OFS_RST)) u_wr (
        .wclk(wclk), .rst(rst), .wen_n(wen_n), .ld_n(ld_n), .din(d),
        .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .ofs_ae(ofs_ae), .ofs_af(ofs_af), .flags(wf)
    );

    dcfifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .din(rgray), .dout(rgray_s));
    dcfifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .din(wgray), .dout(wgray_s));

    dcfifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(d),
        .raddr(raddr), .rdata(mem_q)
    );

    dcfifo_rd_ctl #(.DW(DATA_W), .AW(ADDR_W), .OW(OFS_W)) u_rd (
        .rclk(rclk), .rst(rst), .ren_n(ren_n), .ld_n(ld_n),
        .mode(rd_mode_e'(fwft)), .wgray_s(wgray_s),
        .ofs_ae(ofs_ae), .ofs_af(ofs_af), .mem_q(mem_q),
        .raddr(raddr), .rgray(rgray), .flags(rf), .dout(q_int)
    );

    assign space_ok       = wf.room;
    assign almost_full_n  = wf.afull_n;
    assign over_half_n    = wf.half_n;
    assign data_ok        = rf.avail;
    assign almost_empty_n = rf.aempty_n;
    assign q              = oe_n ? {DATA_W{1'bz}} : q_int;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
`timescale 1ns/1ps
module dcfifo_pflag_chk #(
    parameter int AW = 10
) (
    input logic        wclk,
    input logic        rclk,
    input logic        rst,
    input logic        fwft,
    input logic        wen_n,
    input logic        ren_n,
    input logic        ld_n,
    input logic        space_ok,
    input logic        data_ok,
    input logic        almost_empty_n,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray
);
    // R2
    full_drop_chk: assert property (@(posedge wclk) disable iff (rst)
        (!space_ok && !wen_n) |=> $stable(wgray));

    // R10
    ld_wr_hold_chk: assert property (@(posedge wclk) disable iff (rst)
        (!ld_n && !wen_n) |=> $stable(wgray));

    // R11
    ld_rd_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        (!fwft && !ld_n && !ren_n) |=> $stable(rgray));

    // R3
    empty_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        (!fwft && !data_ok) |=> $stable(rgray));

    // R1
    rst_flags_chk: assert property (@(posedge rclk) disable iff (rst)
        $past(rst) |-> (!data_ok && !almost_empty_n));

    // R12
    fwft_keep_chk: assert property (@(posedge rclk) disable iff (rst)
        (fwft && data_ok && ren_n) |=> data_ok);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.AW(ADDR_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .fwft(fwft),
    .wen_n(wen_n), .ren_n(ren_n), .ld_n(ld_n),
    .space_ok(space_ok), .data_ok(data_ok), .almost_empty_n(almost_empty_n),
    .wgray(wgray), .rgray(rgray)
);

// File: tb/dcfifo_pflag_test.sv
`timescale 1ns/1ps
module dcfifo_pflag_test;
    localparam int DEPTH = 1024;

    logic wclk = 1'b0, rclk = 1'b0;
    logic rst = 1'b1, fwft = 1'b0, wen_n = 1'b1, ren_n = 1'b1, ld_n = 1'b1, oe_n = 1'b0;
    logic [17:0] d = '0;
    logic [17:0] q;
    logic space_ok, data_ok, almost_full_n, almost_empty_n, over_half_n;

    int n_chk = 0, n_err = 0;
    logic [17:0] mq[$];
    int ae_ofs = 127, af_ofs = 127;
    bit wdone;

    always #5   wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    dcfifo_pflag uut (
        .wclk(wclk), .rclk(rclk), .rst(rst), .fwft(fwft),
        .wen_n(wen_n), .ren_n(ren_n), .ld_n(ld_n), .oe_n(oe_n),
        .d(d), .q(q), .space_ok(space_ok), .data_ok(data_ok),
        .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
        .over_half_n(over_half_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] b2w(input bit b);
        return b ? 32'd1 : 32'd0;
    endfunction

    task automatic do_reset(input logic mode);
        rst = 1'b1; fwft = mode; wen_n = 1'b1; ren_n = 1'b1; ld_n = 1'b1;
        mq.delete(); ae_ofs = 127; af_ofs = 127;
        repeat (6) @(negedge rclk);
        rst = 1'b0;
        repeat (4) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (3) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic write_try(input logic [17:0] v, output bit ok);
        @(negedge wclk);
        ok = space_ok; d = v; wen_n = 1'b0;
        @(negedge wclk);
        wen_n = 1'b1;
        if (ok) mq.push_back(v);
    endtask

    task automatic read_std(output bit had);
        logic [17:0] e;
        @(negedge rclk);
        had = data_ok; ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1;
        if (had) begin
            e = mq.pop_front();
            check("R4 order", 32'(q), 32'(e));
        end
    endtask

    task automatic ld_write(input logic [11:0] v);
        @(negedge wclk);
        ld_n = 1'b0; wen_n = 1'b0; d = {6'h15, v};
        @(negedge wclk);
        wen_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic ld_read(output logic [17:0] v);
        @(negedge rclk);
        ld_n = 1'b0; ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1; ld_n = 1'b1;
        v = q;
    endtask

    // Standard-mode flag expectations for a quiet buffer holding n words
    task automatic check_levels(input int n);
        check("R6 data_ok", b2w(data_ok), b2w(n > 0));
        check("R5 space_ok", b2w(space_ok), b2w(n < DEPTH));
        check("R7 almost_empty_n", b2w(almost_empty_n), b2w(!(n <= ae_ofs)));
        check("R8 almost_full_n", b2w(almost_full_n), b2w(!((DEPTH - n) <= af_ofs)));
        check("R9 over_half_n", b2w(over_half_n), b2w(!(n > DEPTH / 2)));
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit ok, had;
        logic [17:0] v, hold;
        int cnt;
        int tg[8] = '{1, 20, 21, 512, 513, 993, 994, 1024};
        void'($urandom(32'd1357));

        // Reset state, standard mode
        do_reset(1'b0);
        check_levels(0);   // R1
        ld_read(v); check("R1 R11 empty ofs default", 32'(v), 32'd127);
        ld_read(v); check("R1 R11 full ofs default", 32'(v), 32'd127);

        // Offset load with wrap: 50 -> ae, 30 -> af, 20 -> ae
        ld_write(12'd50); ld_write(12'd30); ld_write(12'd20);
        ae_ofs = 20; af_ofs = 30;
        settle();
        check("R10 no memory write", b2w(data_ok), 32'd0);
        ld_read(v); check("R10 R11 empty ofs", 32'(v), 32'd20);
        ld_read(v); check("R10 R11 full ofs", 32'(v), 32'd30);

        // Directed fill through every threshold edge
        cnt = 0;
        foreach (tg[i]) begin
            while (cnt < tg[i]) begin
                write_try(18'($urandom), ok);
                if (ok) cnt++;
                else begin check("R2 unexpected refusal", 0, 1); cnt = tg[i]; end
            end
            if (tg[i] == DEPTH) check("R5 full without lag", b2w(space_ok), 32'd0);
            settle();
            check_levels(tg[i]);
        end

        // Overflow attempt is dropped
        write_try(18'h2AAAA, ok);
        check("R2 write refused when full", b2w(ok), 32'd0);

        // Offset read-back removes nothing
        ld_read(v); check("R11 readback while full", 32'(v), 32'd20);
        settle();
        check("R11 no pop", b2w(space_ok), 32'd0);

        // Drain in order
        for (int i = 0; i < DEPTH; i++) begin
            read_std(had);
            check("R6 data present", b2w(had), 32'd1);
            if (i == 0) begin
                hold = q;
                repeat (3) @(negedge rclk);
                check("R3 hold with ren_n high", 32'(q), 32'(hold));
            end
            if (i == DEPTH - 1) check("R6 empty without lag", b2w(data_ok), 32'd0);
        end
        hold = q;
        read_std(had);
        check("R3 empty read ignored", 32'(q), 32'(hold));
        settle();
        check_levels(0);

        // Random concurrent traffic, standard mode
        wdone = 1'b0;
        fork
            begin
                for (int i = 0; i < 1500; i++) begin
                    @(negedge wclk);
                    if ($urandom % 10 < 6) begin
                        v = 18'($urandom); d = v; wen_n = 1'b0;
                        if (space_ok) mq.push_back(v);
                    end else wen_n = 1'b1;
                end
                @(negedge wclk); wen_n = 1'b1;
                wdone = 1'b1;
            end
            begin
                bit pend = 1'b0;
                logic [17:0] e;
                int guard = 0;
                while (!(wdone && mq.size() == 0 && !pend) && guard < 20000) begin
                    @(negedge rclk); guard++;
                    if (pend) begin check("R4 random order", 32'(q), 32'(e)); pend = 1'b0; end
                    if ($urandom % 2 == 0) begin
                        ren_n = 1'b0;
                        if (data_ok) begin e = mq.pop_front(); pend = 1'b1; end
                    end else ren_n = 1'b1;
                end
                ren_n = 1'b1;
            end
        join
        settle();
        check_levels(0);

        // Fall-through mode
        do_reset(1'b1);
        check("R12 nothing valid after reset", b2w(data_ok), 32'd0);
        write_try(18'h1C3A5, ok);
        settle();
        check("R12 head shown without read", b2w(data_ok), 32'd1);
        check("R12 head value", 32'(q), 32'h1C3A5);
        wdone = 1'b0;
        fork
            begin
                for (int i = 0; i < 800; i++) begin
                    @(negedge wclk);
                    if ($urandom % 2 == 0) begin
                        v = 18'($urandom); d = v; wen_n = 1'b0;
                        if (space_ok) mq.push_back(v);
                    end else wen_n = 1'b1;
                end
                @(negedge wclk); wen_n = 1'b1;
                wdone = 1'b1;
            end
            begin
                int guard = 0;
                while (!(wdone && mq.size() == 0) && guard < 20000) begin
                    @(negedge rclk); guard++;
                    if (data_ok) begin
                        check("R12 presented word", 32'(q), 32'(mq[0]));
                        if ($urandom % 3 != 0) begin ren_n = 1'b0; void'(mq.pop_front()); end
                        else ren_n = 1'b1;
                    end else ren_n = 1'b1;
                end
                @(negedge rclk); ren_n = 1'b1;
            end
        join
        settle();
        check("R12 empty after drain", b2w(data_ok), 32'd0);

        // Output enable
        oe_n = 1'b1; #1;
        check("R13 bus released", (q === {18{1'bz}}) ? 32'd1 : 32'd0, 32'd1);
        oe_n = 1'b0; #1;
        check("R13 bus driven", (^q !== 1'bx) ? 32'd1 : 32'd0, 32'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule